// File: doc/BRIEF.md
# Mark Detection Position Latch

This block watches a set of external command inputs for a mark. One of them is picked by a select field. Each rising edge on the picked input, after it has been synchronised, latches the current position value. The latched value is corrected for sensor delay by subtracting velocity times a signed compensation time, and the result is held to the signed range of the position. A value is stored only when it lies inside a configured inclusive window.

Stored values go into a small result array. A signed mode field sets the storage pattern:
- **Zero** keeps only the newest value in slot 0.
- **A positive count** fills slots from 0 upward and then stops with a done flag.
- **A negative count** writes the slots as a ring whose length is the magnitude.

The configuration is taken when the ready input rises, and that same edge clears all results. A separate range strobe reloads only the window limits.

Top module: `mark_latch`

## Requirements
- R1: Input select 0 disables detection. A select value k in 1..NUM_IN uses ext_i[k-1]. A value above NUM_IN disables detection. Edges on inputs that are not selected have no effect.
- R2: A low-to-high change on the selected input is first registered at clock edge t and is captured at edge t+2, using pos_i and vel_i as present at that edge. A level held high yields exactly one capture.
- R3: The captured value is pos_i − vel_i × comp, computed at full width and then saturated to the signed POS_W range.
- R4: A captured value is accepted only if lo ≤ value ≤ hi, both signed and inclusive. When lo > hi nothing is accepted, and a rejected capture changes no output.
- R5: Mode 0 writes each accepted value to slot 0 and adds one to cnt_o, wrapping modulo 2^CNT_W. done_o stays 0.
- R6: Mode m > 0 stores accepted values into slots 0, 1, … in order, up to min(m, DEPTH) entries. done_o rises when that number is reached, and later edges are ignored until the next ready rise.
- R7: Mode m < 0 writes accepted values circularly into slots 0 … L−1, where L = min(|m|, DEPTH), starting at slot 0. cnt_o adds one per value, wrapping modulo 2^CNT_W.
- R8: The clock edge at which rdy_i is 1 and was 0 at the previous edge loads select, compensation, mode and both limits. It clears cnt_o, done_o, all slots and the ring position. A mark captured at that same edge is dropped.
- R9: rng_i high at an edge reloads only hi and lo and clears nothing. A mark captured at that same edge is judged against the old window.
- R10: After reset, cnt_o, done_o and all slots are 0 and detection is disabled until the first ready rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_i | input | NUM_IN | External command inputs (asynchronous) |
| pos_i | input | POS_W | Signed position feed |
| vel_i | input | VEL_W | Signed velocity, position units per microsecond |
| cfg_sel_i | input | SEL_W | Input select, 0 disables |
| cfg_cmp_i | input | CMP_W | Signed compensation time in microseconds |
| cfg_mode_i | input | MODE_W | Signed mode: 0, +count, −ring length |
| cfg_hi_i | input | POS_W | Signed window upper limit |
| cfg_lo_i | input | POS_W | Signed window lower limit |
| rdy_i | input | 1 | Ready; rising edge loads configuration and clears results |
| rng_i | input | 1 | Window reload strobe |
| res_o | output | DEPTH*POS_W | Result slots, slot i at bits [i*POS_W +: POS_W] |
| cnt_o | output | CNT_W | Detection count |
| done_o | output | 1 | Fixed-count completion flag |

## Verification
The bench builds the block with DEPTH=4, CNT_W=4 and four inputs. At these sizes the count wraps after sixteen accepted marks, a ring of three visibly wraps, and a mode magnitude of nine shows the clamp to the array depth. The full 32-bit position width is kept, so both saturation limits of the compensation are reached.

// File: rtl/mark_pkg.sv
package mark_pkg;
    typedef enum logic [1:0] {
        MD_LATEST = 2'd0,
        MD_COUNT  = 2'd1,
        MD_RING   = 2'd2
    } mark_mode_e;
endpackage

// File: rtl/mark_sync.sv
module mark_sync #(
    parameter int NUM_IN = 4,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] ext_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              hit_o
);
    logic [NUM_IN-1:0] s1_q, s2_q, s3_q;
    logic [NUM_IN-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= ext_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;

    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (32'(sel_i) == i + 1) hit_o = rise[i];
        end
    end
endmodule

// File: rtl/mark_comp.sv
module mark_comp #(
    parameter int POS_W = 32,
    parameter int VEL_W = 16,
    parameter int CMP_W = 16
) (
    input  logic signed [POS_W-1:0] pos_i,
    input  logic signed [VEL_W-1:0] vel_i,
    input  logic signed [CMP_W-1:0] cmp_i,
    output logic signed [POS_W-1:0] val_o
);
    localparam int PRD_W = VEL_W + CMP_W;
    localparam int SUM_W = ((POS_W > PRD_W) ? POS_W : PRD_W) + 1;
    localparam logic signed [SUM_W-1:0] ONE  = 1;
    localparam logic signed [SUM_W-1:0] MAXV = (ONE <<< (POS_W - 1)) - ONE;
    localparam logic signed [SUM_W-1:0] MINV = -(ONE <<< (POS_W - 1));

    logic signed [PRD_W-1:0] prod;
    logic signed [SUM_W-1:0] pos_x, prod_x, diff;

    always_comb begin
        prod   = vel_i * cmp_i;
        pos_x  = {{(SUM_W - POS_W){pos_i[POS_W-1]}}, pos_i};
        prod_x = {{(SUM_W - PRD_W){prod[PRD_W-1]}}, prod};
        diff   = pos_x - prod_x;
        if (diff > MAXV)      val_o = MAXV[POS_W-1:0];
        else if (diff < MINV) val_o = MINV[POS_W-1:0];
        else                  val_o = diff[POS_W-1:0];
    end
endmodule

// File: rtl/mark_window.sv
module mark_window #(
    parameter int POS_W = 32
) (
    input  logic signed [POS_W-1:0] val_i,
    input  logic signed [POS_W-1:0] hi_i,
    input  logic signed [POS_W-1:0] lo_i,
    output logic                    ok_o
);
    assign ok_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/mark_latch.sv
module mark_latch
    import mark_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int SEL_W  = 5,
    parameter int POS_W  = 32,
    parameter int VEL_W  = 16,
    parameter int CMP_W  = 16,
    parameter int DEPTH  = 8,
    parameter int MODE_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       ext_i,
    input  logic [POS_W-1:0]        pos_i,
    input  logic [VEL_W-1:0]        vel_i,
    input  logic [SEL_W-1:0]        cfg_sel_i,
    input  logic [CMP_W-1:0]        cfg_cmp_i,
    input  logic [MODE_W-1:0]       cfg_mode_i,
    input  logic [POS_W-1:0]        cfg_hi_i,
    input  logic [POS_W-1:0]        cfg_lo_i,
    input  logic                    rdy_i,
    input  logic                    rng_i,
    output logic [DEPTH*POS_W-1:0]  res_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    done_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LIM_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                         rdy;
        logic [SEL_W-1:0]             sel;
        logic [CMP_W-1:0]             cmp;
        logic [MODE_W-1:0]            mode;
        logic [POS_W-1:0]             hi;
        logic [POS_W-1:0]             lo;
        logic [CNT_W-1:0]             cnt;
        logic                         done;
        logic [IDX_W-1:0]             wptr;
        logic [DEPTH-1:0][POS_W-1:0]  slot;
    } st_t;

    st_t st_d, st_q;

    logic              hit, in_win, rdy_rise;
    logic [POS_W-1:0]  val;
    logic [MODE_W-1:0] mag;
    logic [LIM_W-1:0]  lim;
    mark_mode_e        kind;

    mark_sync #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .ext_i (ext_i),
        .sel_i (st_q.sel),
        .hit_o (hit)
    );

    mark_comp #(.POS_W(POS_W), .VEL_W(VEL_W), .CMP_W(CMP_W)) u_comp (
        .pos_i (pos_i),
        .vel_i (vel_i),
        .cmp_i (st_q.cmp),
        .val_o (val)
    );

    mark_window #(.POS_W(POS_W)) u_win (
        .val_i (val),
        .hi_i  (st_q.hi),
        .lo_i  (st_q.lo),
        .ok_o  (in_win)
    );

    assign rdy_rise = rdy_i & ~st_q.rdy;

    always_comb begin
        mag = st_q.mode[MODE_W-1] ? (~st_q.mode + 1'b1) : st_q.mode;
        lim = (32'(mag) > 32'(DEPTH)) ? LIM_W'(DEPTH) : LIM_W'(mag);
        if (st_q.mode == '0)            kind = MD_LATEST;
        else if (!st_q.mode[MODE_W-1])  kind = MD_COUNT;
        else                            kind = MD_RING;
    end

    always_comb begin
        st_d     = st_q;
        st_d.rdy = rdy_i;
        if (rdy_rise) begin
            st_d.sel  = cfg_sel_i;
            st_d.cmp  = cfg_cmp_i;
            st_d.mode = cfg_mode_i;
            st_d.hi   = cfg_hi_i;
            st_d.lo   = cfg_lo_i;
            st_d.cnt  = '0;
            st_d.done = 1'b0;
            st_d.wptr = '0;
            st_d.slot = '0;
        end else begin
            if (rng_i) begin
                st_d.hi = cfg_hi_i;
                st_d.lo = cfg_lo_i;
            end
            if (hit && in_win) begin
                case (kind)
                    MD_LATEST: begin
                        st_d.slot[0] = val;
                        st_d.cnt     = st_q.cnt + 1'b1;
                    end
                    MD_COUNT: begin
                        if (!st_q.done) begin
                            st_d.slot[st_q.cnt[IDX_W-1:0]] = val;
                            st_d.cnt = st_q.cnt + 1'b1;
                            if (32'(st_q.cnt) + 32'd1 == 32'(lim)) st_d.done = 1'b1;
                        end
                    end
                    default: begin
                        st_d.slot[st_q.wptr] = val;
                        st_d.wptr = (32'(st_q.wptr) + 32'd1 >= 32'(lim)) ? '0 : st_q.wptr + 1'b1;
                        st_d.cnt  = st_q.cnt + 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o  = st_q.slot;
    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;
endmodule

// File: rtl/mark_latch_chk.sv
module mark_latch_chk #(
    parameter int POS_W  = 32,
    parameter int SEL_W  = 5,
    parameter int MODE_W = 7,
    parameter int CNT_W  = 8,
    parameter int LIM_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit,
    input logic              in_win,
    input logic              rdy_rise,
    input logic [SEL_W-1:0]  sel,
    input logic [MODE_W-1:0] mode,
    input logic [LIM_W-1:0]  lim,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              done_o
);
    // R1: a disabled select never moves the count
    p_off_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && !rdy_rise) |=> $stable(cnt_o));

    // R4: a capture outside the window leaves the count alone
    p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !in_win && !rdy_rise) |=> $stable(cnt_o));

    // R5: done is never raised outside fixed-count mode
    p_done_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mode[MODE_W-1] && mode != '0));

    // R6: fixed-count mode never exceeds its limit
    p_fixed_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[MODE_W-1] && mode != '0) |-> (32'(cnt_o) <= 32'(lim)));

    // R6: done stays up until a ready rise
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rdy_rise) |=> done_o);

    // R8: a ready rise clears count and done
    p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_rise |=> (cnt_o == '0 && !done_o));
endmodule

bind mark_latch mark_latch_chk #(
    .POS_W(POS_W), .SEL_W(SEL_W), .MODE_W(MODE_W), .CNT_W(CNT_W), .LIM_W(LIM_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .in_win   (in_win),
    .rdy_rise (rdy_rise),
    .sel      (st_q.sel),
    .mode     (st_q.mode),
    .lim      (lim),
    .cnt_o    (cnt_o),
    .done_o   (done_o)
);

// File: tb/sim_mark_latch.sv
module sim_mark_latch;
    localparam int TD = 4;
    localparam int TC = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         ext = '0;
    logic signed [31:0] pos = '0;
    logic signed [15:0] vel = '0;
    logic [4:0]         sel = '0;
    logic signed [15:0] cmp = '0;
    logic signed [6:0]  mode = '0;
    logic signed [31:0] hi = '0;
    logic signed [31:0] lo = '0;
    logic               rdy = 1'b0;
    logic               rng = 1'b0;
    logic [TD*32-1:0]   res;
    logic [TC-1:0]      cnt;
    logic               done;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    // behavioural reference state
    bit [3:0] m1, m2, m3;
    bit       m_rdy;
    int       m_sel, m_mode, m_cnt, m_wp;
    bit       m_done;
    longint   m_cmp, m_hi, m_lo;
    longint   m_slot [TD];

    mark_latch #(
        .NUM_IN(4), .SEL_W(5), .POS_W(32), .VEL_W(16), .CMP_W(16),
        .DEPTH(TD), .MODE_W(7), .CNT_W(TC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ext_i(ext), .pos_i(pos), .vel_i(vel),
        .cfg_sel_i(sel), .cfg_cmp_i(cmp), .cfg_mode_i(mode),
        .cfg_hi_i(hi), .cfg_lo_i(lo), .rdy_i(rdy), .rng_i(rng),
        .res_o(res), .cnt_o(cnt), .done_o(done)
    );

    always #2 clk = ~clk;

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint slot_of(int i);
        return longint'($signed(res[i*32 +: 32]));
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 = '0; m2 = '0; m3 = '0; m_rdy = 0;
            m_sel = 0; m_mode = 0; m_cnt = 0; m_wp = 0; m_done = 0;
            m_cmp = 0; m_hi = 0; m_lo = 0;
            for (int i = 0; i < TD; i++) m_slot[i] = 0;
        end else begin
            bit     fire;
            longint v;
            int     lim;
            fire = 0;
            if (m_sel >= 1 && m_sel <= 4) fire = m2[m_sel-1] && !m3[m_sel-1];
            v = longint'(pos) - longint'(vel) * m_cmp;
            if (v > 64'sd2147483647) v = 64'sd2147483647;
            if (v < -64'sd2147483648) v = -64'sd2147483648;
            if (rdy && !m_rdy) begin
                m_sel = int'(sel); m_cmp = longint'(cmp); m_mode = int'(mode);
                m_hi = longint'(hi); m_lo = longint'(lo);
                m_cnt = 0; m_done = 0; m_wp = 0;
                for (int i = 0; i < TD; i++) m_slot[i] = 0;
            end else begin
                if (fire && v >= m_lo && v <= m_hi) begin
                    if (m_mode == 0) begin
                        m_slot[0] = v;
                        m_cnt = (m_cnt + 1) % (1 << TC);
                    end else if (m_mode > 0) begin
                        lim = (m_mode > TD) ? TD : m_mode;
                        if (!m_done) begin
                            m_slot[m_cnt] = v;
                            m_cnt++;
                            if (m_cnt == lim) m_done = 1;
                        end
                    end else begin
                        lim = (-m_mode > TD) ? TD : -m_mode;
                        m_slot[m_wp] = v;
                        m_wp = (m_wp + 1) % lim;
                        m_cnt = (m_cnt + 1) % (1 << TC);
                    end
                end
                if (rng) begin
                    m_hi = longint'(hi); m_lo = longint'(lo);
                end
            end
            m3 = m2; m2 = m1; m1 = ext; m_rdy = rdy;
        end
    end

    // per-cycle comparison against the model, tagged by storage mode
    always @(negedge clk) begin
        if (rst_n) begin
            string tag;
            bit    bad;
            tag = (m_mode == 0) ? "R5" : (m_mode > 0) ? "R6" : "R7";
            bad = (int'(cnt) != m_cnt) || (done != m_done);
            for (int i = 0; i < TD; i++) if (slot_of(i) != m_slot[i]) bad = 1;
            total++;
            if (bad) begin
                fails++;
                $display("FAIL %s model: cnt %0d/%0d done %0d/%0d slot0 %0d/%0d",
                         tag, cnt, m_cnt, done, m_done, slot_of(0), m_slot[0]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic configure(int s, int c, int md, longint h, longint l);
        @(negedge clk);
        sel = 5'(s); cmp = 16'(c); mode = 7'(md); hi = 32'(h); lo = 32'(l);
        rdy = 1'b0;
        @(negedge clk); rdy = 1'b1;
        @(negedge clk); rdy = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(int idx, int hold);
        @(negedge clk); ext[idx] = 1'b1;
        repeat (hold) @(negedge clk);
        ext[idx] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_at(int idx, longint p);
        pos = 32'(p);
        pulse(idx, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 cnt", cnt, 0);
        check("R10 done", done, 0);
        check("R10 slots", res == '0, 1);
        rst_n = 1'b1;
        pulse(0, 3);
        check("R10 disabled before ready", cnt, 0);

        // R1: select 0 disables
        configure(0, 0, 0, 64'sd2147483647, -64'sd2147483648);
        pulse(0, 3);
        check("R1 select zero", cnt, 0);
        configure(7, 0, 0, 64'sd2147483647, -64'sd2147483648);
        pulse(3, 3);
        check("R1 select beyond inputs", cnt, 0);

        // R2, R3: capture with compensation, held level
        configure(2, 10, 0, 64'sd2147483647, -64'sd2147483648);
        pos = 1000; vel = 3;
        pulse(1, 8);
        check("R2 one capture per held level", cnt, 1);
        check("R3 compensated value", slot_of(0), 970);
        pulse_at(0, 5);
        check("R1 unselected input ignored", cnt, 1);
        check("R1 unselected slot unchanged", slot_of(0), 970);

        // R5: counter wraps
        vel = 0;
        for (int k = 0; k < 17; k++) pulse_at(1, 100 + k);
        check("R5 count wraps", cnt, 2);
        check("R5 latest kept", slot_of(0), 116);
        check("R5 done low", done, 0);

        // R3: saturation both ways (cmp = 10)
        vel = -16'sd1000;
        pulse_at(1, 64'sd2147483600);
        check("R3 positive saturation", slot_of(0), 64'sd2147483647);
        vel = 16'sd1000;
        pulse_at(1, -64'sd2147483600);
        check("R3 negative saturation", slot_of(0), -64'sd2147483648);
        vel = 0;

        // R4: window
        @(negedge clk); hi = 500; lo = -500; rng = 1'b1;
        @(negedge clk); rng = 1'b0;
        pulse_at(1, 600);
        check("R4 above window rejected", cnt, 4);
        pulse_at(1, 500);
        check("R4 upper edge accepted", slot_of(0), 500);
        pulse_at(1, -500);
        check("R4 lower edge accepted", slot_of(0), -500);
        @(negedge clk); hi = -1; lo = 1; rng = 1'b1;
        @(negedge clk); rng = 1'b0;
        pulse_at(1, 0);
        check("R4 inverted window rejects", cnt, 6);

        // R9: range strobe coincident with capture uses old window
        configure(2, 0, 0, 64'sd2147483647, -64'sd2147483648);
        pos = 200;
        @(negedge clk); ext[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); hi = 100; lo = 0; rng = 1'b1;
        @(negedge clk); rng = 1'b0; ext[1] = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 old window at strobe edge", cnt, 1);
        pulse_at(1, 200);
        check("R9 new window active", cnt, 1);
        pulse_at(1, 50);
        check("R9 no clear on strobe", cnt, 2);

        // R8: mark at the ready-rise edge is dropped
        sel = 2; cmp = 0; mode = 0; hi = 32'h7fffffff; lo = 32'h80000000;
        pos = 77;
        @(negedge clk); ext[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); rdy = 1'b1;
        @(negedge clk); rdy = 1'b0; ext[1] = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 clear and drop", cnt, 0);
        check("R8 slot cleared", slot_of(0), 0);

        // R6: fixed count of 3
        configure(2, 0, 3, 64'sd2147483647, -64'sd2147483648);
        pulse_at(1, 11); pulse_at(1, 22);
        check("R6 not done early", done, 0);
        pulse_at(1, 33); pulse_at(1, 44);
        check("R6 done", done, 1);
        check("R6 count", cnt, 3);
        check("R6 slot2", slot_of(2), 33);
        check("R6 slot3 untouched", slot_of(3), 0);

        // R7: ring of three
        configure(2, 0, -3, 64'sd2147483647, -64'sd2147483648);
        check("R8 done cleared", done, 0);
        for (int k = 1; k <= 5; k++) pulse_at(1, k);
        check("R7 ring slot0", slot_of(0), 4);
        check("R7 ring slot1", slot_of(1), 5);
        check("R7 ring slot2", slot_of(2), 3);
        check("R7 ring slot3 unused", slot_of(3), 0);
        check("R7 count", cnt, 5);

        // R7: magnitude clamped to depth
        configure(2, 0, -9, 64'sd2147483647, -64'sd2147483648);
        for (int k = 10; k <= 14; k++) pulse_at(1, k);
        check("R7 clamp slot0", slot_of(0), 14);
        check("R7 clamp slot3", slot_of(3), 13);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule